// File: doc/BRIEF.md
# Teletype Port Controller

This block sits between a byte-wide CPU I/O bus and a single character terminal line. The bus side offers four operations selected by an opcode with a one-cycle strobe: command write, data read, data write and status read. The line side delivers received characters as a strobe with a byte and a break flag, and takes transmitted bytes through a valid/ready handshake. Bit timing, interrupt steering and character-set conversion are handled elsewhere.

The port is always in either read mode or write mode, and one busy flag serves whichever direction is selected. When software switches direction, the flag is re-evaluated against the state of that direction. The block tracks a pending received character so that it can report overrun. It reports break and raises an interrupt request when the interrupt is armed. In half-duplex mode it echoes received characters back to the line as 7-bit data.

Bus opcodes are 00 command write, 01 data read, 10 data write and 11 status read. Read data is combinational during the strobe cycle. State changes take effect at the clock edge that ends the strobe.

Top module: `tty_port_ctrl`

## Requirements
- R1: After reset the port is in read mode and full duplex. The interrupt is disarmed, no character is pending, no transmit byte is held, irq_o is 0 and status reads 0x08.
- R2: The status byte has overrun at bit 7, break at bit 5, busy at bit 3 and exception at bit 2. Exception is set when overrun or break is set. All other bits read 0.
- R3: Command bits 7:6 control the interrupt arm, bits 5:4 control duplex (set means full duplex) and bits 3:2 control direction (set means read mode). Each field is encoded 01 = set, 10 = clear, 00 or 11 = no change.
- R4: A command that changes direction clears overrun and break. It also clears busy and raises irq_o if armed, provided that it enters read mode with a character pending or enters write mode with no transmit byte held. In every other case it sets busy and drops irq_o.
- R5: A command that leaves the direction unchanged clears overrun and leaves busy, break and irq_o as they were.
- R6: A data read returns the receive buffer and clears the pending flag. In read mode it also sets busy and clears overrun.
- R7: A data write loads the byte and asserts tx_valid_o. In write mode it also sets busy. While tx_ready_i is low the byte and tx_valid_o are held, and busy stays set.
- R8: When a host byte is accepted by the line in write mode, busy is cleared and irq_o is raised if armed.
- R9: A received character in read mode clears busy and raises irq_o if armed. It sets overrun if a character was already pending. In either mode the pending flag is then set.
- R10: A received break sets the break bit and loads 0x00 into the receive buffer, and it is not echoed. The break bit clears at the next receive strobe without break.
- R11: In half duplex, a received character is echoed on the transmit side with bit 7 forced to 0. The echo is dropped if a transmit byte is already held, and its acceptance does not change busy.
- R12: irq_o never rises while the interrupt is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_stb_i | input | 1 | Bus operation strobe, one cycle |
| bus_op_i | input | 2 | 00 command, 01 data read, 10 data write, 11 status read |
| bus_wdata_i | input | 8 | Command or transmit byte |
| bus_rdata_o | output | 8 | Receive buffer or status, valid during strobe |
| rx_stb_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_brk_i | input | 1 | Received event is a break |
| tx_valid_o | output | 1 | Transmit byte held |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Line accepts transmit byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check four things. A data read in read mode or a data write in write mode leaves busy set. A repeated character in read mode produces overrun. irq_o rises only while armed. A stalled transmit byte stays frozen, and an echoed byte never carries bit 7. Only the bench scenarios can show the direction-change evaluation in its pending and idle variants, and the ordering of busy and interrupt across a stalled host write. They also cover break set-and-clear, echo drop on collision, and the exact byte sequence seen on the line.

// File: rtl/tty_pkg.sv
package tty_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_CMD    = 2'b00,
    OP_RDATA  = 2'b01,
    OP_WDATA  = 2'b10,
    OP_STATUS = 2'b11
  } bus_op_e;

  // command field positions (low bit of each 2-bit field)
  localparam int unsigned CMD_ARM_LSB = 6;
  localparam int unsigned CMD_DPX_LSB = 4;
  localparam int unsigned CMD_DIR_LSB = 2;

  // status bit positions
  localparam int unsigned ST_OVR  = 7;
  localparam int unsigned ST_BRK  = 5;
  localparam int unsigned ST_BUSY = 3;
  localparam int unsigned ST_EXC  = 2;

  function automatic logic apply_field(input logic [1:0] f, input logic cur);
    case (f)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/tty_tx_hold.sv
module tty_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [DW-1:0] host_data_i,
  input  logic          echo_req_i,
  input  logic [DW-1:0] echo_data_i,
  input  logic          tx_ready_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          host_done_o,
  output logic          idle_o
);
  logic          valid_q, echo_q;
  logic [DW-1:0] data_q;
  logic          accept;

  assign accept = valid_q && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      echo_q  <= 1'b0;
      data_q  <= '0;
    end else if (host_we_i) begin
      valid_q <= 1'b1;
      echo_q  <= 1'b0;
      data_q  <= host_data_i;
    end else if (accept) begin
      valid_q <= 1'b0;
      echo_q  <= 1'b0;
    end else if (echo_req_i && !valid_q) begin
      valid_q <= 1'b1;
      echo_q  <= 1'b1;
      data_q  <= echo_data_i;
    end
  end

  assign tx_valid_o  = valid_q;
  assign tx_data_o   = data_q;
  assign host_done_o = accept && !echo_q;
  assign idle_o      = !valid_q;

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !tx_ready_i && !host_we_i |=> valid_q && $stable(data_q));

  assert_echo_7bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && echo_q |-> !data_q[DW-1]);
endmodule

// File: rtl/tty_ctrl_core.sv
module tty_ctrl_core
  import tty_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              rd_re_i,
  input  logic              wr_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rx_stb_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_brk_i,
  input  logic              tx_done_i,
  input  logic              tx_idle_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] rx_buf_o,
  output logic              echo_req_o,
  output logic [BYTE_W-1:0] echo_data_o,
  output logic              irq_o
);
  logic rd_q, fdx_q, arm_q, busy_q, ovr_q, brk_q, pend_q, irq_q;
  logic rd_d, fdx_d, arm_d, busy_d, ovr_d, brk_d, pend_d, irq_d;
  logic [BYTE_W-1:0] buf_q, buf_d;

  always_comb begin
    rd_d = rd_q; fdx_d = fdx_q; arm_d = arm_q; busy_d = busy_q;
    ovr_d = ovr_q; brk_d = brk_q; pend_d = pend_q; irq_d = irq_q;
    buf_d = buf_q;
    if (cmd_we_i) begin
      arm_d = apply_field(wdata_i[CMD_ARM_LSB +: 2], arm_q);
      fdx_d = apply_field(wdata_i[CMD_DPX_LSB +: 2], fdx_q);
      rd_d  = apply_field(wdata_i[CMD_DIR_LSB +: 2], rd_q);
      if (rd_d != rd_q) begin
        ovr_d = 1'b0;
        brk_d = 1'b0;
        if (rd_d ? pend_q : tx_idle_i) begin
          busy_d = 1'b0;
          if (arm_d) irq_d = 1'b1;
        end else begin
          busy_d = 1'b1;
          irq_d  = 1'b0;
        end
      end else begin
        ovr_d = 1'b0;
      end
    end
    if (rd_re_i) begin
      pend_d = 1'b0;
      if (rd_q) begin
        busy_d = 1'b1;
        ovr_d  = 1'b0;
      end
    end
    if (tx_done_i && !rd_d) begin
      busy_d = 1'b0;
      if (arm_d) irq_d = 1'b1;
    end
    if (wr_we_i && !rd_q) busy_d = 1'b1;
    if (rx_stb_i) begin
      brk_d = rx_brk_i;
      buf_d = rx_brk_i ? '0 : rx_data_i;
      if (rd_d) begin
        busy_d = 1'b0;
        if (arm_d)  irq_d = 1'b1;
        if (pend_d) ovr_d = 1'b1;
      end
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b1; fdx_q <= 1'b1; arm_q <= 1'b0; busy_q <= 1'b1;
      ovr_q <= 1'b0; brk_q <= 1'b0; pend_q <= 1'b0; irq_q <= 1'b0;
      buf_q <= '0;
    end else begin
      rd_q <= rd_d; fdx_q <= fdx_d; arm_q <= arm_d; busy_q <= busy_d;
      ovr_q <= ovr_d; brk_q <= brk_d; pend_q <= pend_d; irq_q <= irq_d;
      buf_q <= buf_d;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_OVR]  = ovr_q;
    status_o[ST_BRK]  = brk_q;
    status_o[ST_BUSY] = busy_q;
    status_o[ST_EXC]  = ovr_q | brk_q;
  end

  assign rx_buf_o    = buf_q;
  assign echo_req_o  = rx_stb_i && !rx_brk_i && !fdx_q;
  assign echo_data_o = {1'b0, rx_data_i[BYTE_W-2:0]};
  assign irq_o       = irq_q;

  assert_rd_sets_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_re_i && rd_q && !cmd_we_i && !rx_stb_i |=> busy_q && !ovr_q);

  assert_wr_sets_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_we_i && !rd_q && !cmd_we_i |=> busy_q);

  assert_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_i && rd_q && pend_q && !cmd_we_i && !rd_re_i |=> ovr_q);

  assert_irq_armed_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> arm_q);
endmodule

// File: rtl/tty_port_ctrl.sv
module tty_port_ctrl
  import tty_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_stb_i,
  input  logic [1:0]        bus_op_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic              rx_stb_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_brk_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic cmd_we, rd_re, wr_we, st_re;
  logic tx_done, tx_idle, echo_req;
  logic [BYTE_W-1:0] status, rx_buf, echo_data;

  assign cmd_we = bus_stb_i && (bus_op_i == OP_CMD);
  assign rd_re  = bus_stb_i && (bus_op_i == OP_RDATA);
  assign wr_we  = bus_stb_i && (bus_op_i == OP_WDATA);
  assign st_re  = bus_stb_i && (bus_op_i == OP_STATUS);

  tty_ctrl_core u_core (
    .clk_i, .rst_ni,
    .cmd_we_i(cmd_we), .rd_re_i(rd_re), .wr_we_i(wr_we), .wdata_i(bus_wdata_i),
    .rx_stb_i, .rx_data_i, .rx_brk_i,
    .tx_done_i(tx_done), .tx_idle_i(tx_idle),
    .status_o(status), .rx_buf_o(rx_buf),
    .echo_req_o(echo_req), .echo_data_o(echo_data), .irq_o
  );

  tty_tx_hold #(.DW(BYTE_W)) u_tx (
    .clk_i, .rst_ni,
    .host_we_i(wr_we), .host_data_i(bus_wdata_i),
    .echo_req_i(echo_req), .echo_data_i(echo_data),
    .tx_ready_i, .tx_valid_o, .tx_data_o,
    .host_done_o(tx_done), .idle_o(tx_idle)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd_re)      bus_rdata_o = rx_buf;
    else if (st_re) bus_rdata_o = status;
  end
endmodule

// File: tb/sim_tty_port_ctrl.sv
module sim_tty_port_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_stb = 1'b0, rx_stb = 1'b0, rx_brk = 1'b0, tx_ready = 1'b1;
  logic [1:0] bus_op = 2'b00;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic [7:0] bus_rdata, tx_data;
  logic tx_valid, irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_rd;

  always #5 clk = ~clk;

  tty_port_ctrl u0 (
    .clk_i(clk), .rst_ni, .bus_stb_i(bus_stb), .bus_op_i(bus_op),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_stb_i(rx_stb), .rx_data_i(rx_data), .rx_brk_i(rx_brk),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] op, input logic [7:0] wd);
    bus_stb = 1'b1; bus_op = op; bus_wdata = wd;
    @(negedge clk) last_rd = bus_rdata;
    @(posedge clk) #1 bus_stb = 1'b0;
  endtask

  task automatic status(input string tag, input logic [7:0] exp);
    bus(2'b11, 8'h00);
    chk(tag, last_rd, exp);
  endtask

  task automatic rdata(input string tag, input logic [7:0] exp);
    bus(2'b01, 8'h00);
    chk(tag, last_rd, exp);
  endtask

  task automatic rx(input logic [7:0] d, input logic b);
    rx_stb = 1'b1; rx_data = d; rx_brk = b;
    @(posedge clk) #1 rx_stb = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk) #1;
  endtask

  // monitor: pops expected line bytes at each handshake
  always @(negedge clk) begin
    if (rst_ni && tx_valid && tx_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 line: actual %02h expected none", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          fails++;
          $display("FAIL R7/R11 line: actual %02h expected %02h", tx_data, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    @(posedge clk) #1;
    // R1 reset state, R2 layout
    status("R1 status", 8'h08);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    // R9 character in read mode
    rx(8'h41, 1'b0);
    status("R9 busy clear", 8'h00);
    chk("R12 unarmed irq", {7'd0, irq}, 8'h00);
    rdata("R6 data", 8'h41);
    status("R6 busy set", 8'h08);
    // R3 arm via bits 7:6, R5 same-direction command
    bus(2'b00, 8'h40);
    status("R5 arm cmd", 8'h08);
    rx(8'h55, 1'b0);
    status("R9 armed", 8'h00);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    rx(8'h66, 1'b0);
    status("R9 overrun R2 exc", 8'h84);
    bus(2'b00, 8'h00);
    status("R5 ovr clear", 8'h00);
    chk("R5 irq kept", {7'd0, irq}, 8'h01);
    rdata("R6 second", 8'h66);
    status("R6 busy", 8'h08);
    // R4 enter write mode with idle transmitter
    tx_ready = 1'b0;
    bus(2'b00, 8'h08);
    status("R4 write idle", 8'h00);
    chk("R4 irq", {7'd0, irq}, 8'h01);
    // R7 stalled host write
    exp_q.push_back(8'hC3);
    bus(2'b10, 8'hC3);
    status("R7 busy", 8'h08);
    chk("R7 valid", {7'd0, tx_valid}, 8'h01);
    chk("R7 data", tx_data, 8'hC3);
    idle(3);
    status("R7 held busy", 8'h08);
    chk("R7 held valid", {7'd0, tx_valid}, 8'h01);
    // R4 enter read, nothing pending
    bus(2'b00, 8'h04);
    status("R4 read no pend", 8'h08);
    chk("R4 irq drop", {7'd0, irq}, 8'h00);
    // R4 enter write with byte held
    bus(2'b00, 8'h08);
    status("R4 write held", 8'h08);
    chk("R4 irq still low", {7'd0, irq}, 8'h00);
    // R8 completion
    tx_ready = 1'b1;
    idle(2);
    status("R8 busy clear", 8'h00);
    chk("R8 irq", {7'd0, irq}, 8'h01);
    chk("R8 valid", {7'd0, tx_valid}, 8'h00);
    // R4 enter read with character pending
    rx(8'h12, 1'b0);
    status("R9 write-mode rx", 8'h00);
    bus(2'b00, 8'h04);
    status("R4 read pend", 8'h00);
    // R10 break
    rx(8'h7A, 1'b1);
    status("R10 brk ovr", 8'hA4);
    chk("R10 no echo", {7'd0, tx_valid}, 8'h00);
    rdata("R10 buf zero", 8'h00);
    status("R10 brk stays", 8'h2C);
    rx(8'h31, 1'b0);
    status("R10 brk clear", 8'h00);
    rdata("R6 after brk", 8'h31);
    // R11 half duplex echo
    bus(2'b00, 8'h20);
    status("R3 duplex cmd", 8'h08);
    exp_q.push_back(8'h45);
    rx(8'hC5, 1'b0);
    idle(2);
    status("R11 busy untouched", 8'h00);
    rdata("R11 buf full byte", 8'hC5);
    // R11 echo dropped on collision
    tx_ready = 1'b0;
    exp_q.push_back(8'h99);
    bus(2'b10, 8'h99);
    status("R7 read-mode write", 8'h08);
    rx(8'h7E, 1'b0);
    chk("R11 drop data", tx_data, 8'h99);
    status("R9 rx", 8'h00);
    tx_ready = 1'b1;
    idle(3);
    chk("R11 queue empty", 8'(exp_q.size()), 8'h00);
    rdata("R6 7E", 8'h7E);
    // R12 disarmed completion
    tx_ready = 1'b0;
    exp_q.push_back(8'h22);
    bus(2'b10, 8'h22);
    bus(2'b00, 8'h88);
    status("R4 write held disarm", 8'h08);
    chk("R4 irq drop", {7'd0, irq}, 8'h00);
    tx_ready = 1'b1;
    idle(2);
    status("R8 busy clear", 8'h00);
    chk("R12 no irq", {7'd0, irq}, 8'h00);
    chk("R7 queue empty", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule